// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a reference clock of any common crystal frequency into a one-cycle tick whose average rate is exactly 1 MHz. It does not use an integer prescaler. A small accumulator adds a numerator on every reference cycle. Each time the running sum reaches a denominator, it subtracts the denominator and emits a tick. Because the sum only carries a remainder forward, ratios such as 5/96 (19.2 MHz) or 5/192 (38.4 MHz) come out exact over time, and no single tick lands more than one reference cycle away from its ideal position.

Both ratio terms are packed into one 16-bit configuration word. The word can be written and read back, so software can save it and restore it. A free-running microsecond counter advances once per tick and wraps at its width. It is visible at all times on an output port, so consumer timers and software can sample it whenever they need to.

Top module: `usec_tick_gen`

## Requirements
- R1: While reset is held, `usec_tick` is 0, `usec_count` is 0 and `cfg_rd_data` is 0x000B. The reset ratio is 1/12, which suits a 12 MHz reference.
- R2: The configuration word holds (numerator-1) in bits 15:8 and (denominator-1) in bits 7:0. `cfg_rd_data` returns the last written word from the cycle after the write.
- R3: Over K reference cycles that start right after a write, the design emits floor(K*num/den) ticks when num < den. Examples: 0x000B gives 80 ticks per 960 cycles, 0x045F gives 50, and 0x04BF gives 25.
- R4: When num < den, the spacing between ticks is always either floor(den/num) or ceil(den/num) cycles. The first tick after a write comes ceil(den/num) cycles after the write edge.
- R5: When num >= den, a tick is emitted on every cycle that is not a write cycle.
- R6: `usec_count` rises by exactly 1 in the same cycle that `usec_tick` is high, holds its value otherwise, and wraps from all ones to 0.
- R7: A configuration write clears the accumulator and suppresses any tick on the write edge. It leaves `usec_count` unchanged.
- R8: After reset is released with the default word, the first tick appears 12 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the ratio word |
| cfg_wr_data | input | 2*FIELD_W (16) | Ratio word to store |
| cfg_rd_data | output | 2*FIELD_W (16) | Stored ratio word |
| usec_tick | output | 1 | One-cycle tick, 1 MHz on average |
| usec_count | output | CNT_W (32) | Free-running tick counter |

## Verification
The bench keeps FIELD_W at 8, so every real crystal ratio can be tried, including the 5/x ratios and the saturated ratios (1/1 and 4/1). It builds the design with CNT_W set to 12. With that width the counter wraps after 4096 ticks, so the wrap from all ones to zero can be observed in a short run. The ratio table covers every listed crystal word, and the bench checks the tick totals and the minimum and maximum tick gaps against values derived from num and den.

// File: rtl/utg_pkg.sv
package utg_pkg;
  localparam int unsigned UTG_FIELD_W  = 8;
  localparam int unsigned UTG_CNT_W    = 32;
  localparam logic [15:0] UTG_CFG_DFLT = 16'h000B;

  typedef enum logic [1:0] {
    STEP_ACCUM    = 2'd0,
    STEP_FIRE     = 2'd1,
    STEP_SATURATE = 2'd2
  } step_kind_e;
endpackage

// File: rtl/utg_cfg_reg.sv
module utg_cfg_reg #(
  parameter int unsigned FIELD_W = utg_pkg::UTG_FIELD_W,
  parameter logic [2*FIELD_W-1:0] RST_CFG = (2*FIELD_W)'(utg_pkg::UTG_CFG_DFLT),
  localparam int unsigned CFG_W = 2 * FIELD_W,
  localparam int unsigned AW = FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_o,
  output logic [AW-1:0]    num_o,
  output logic [AW-1:0]    den_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= RST_CFG;
    else if (wr_en) cfg_q <= wr_data;
  end

  // each field stores its term minus one
  function automatic logic [AW-1:0] field_term(input logic [FIELD_W-1:0] f);
    return {1'b0, f} + AW'(1);
  endfunction

  assign num_o = field_term(cfg_q[CFG_W-1:FIELD_W]);
  assign den_o = field_term(cfg_q[FIELD_W-1:0]);
  assign cfg_o = cfg_q;
endmodule

// File: rtl/utg_frac_accum.sv
module utg_frac_accum #(
  parameter int unsigned FIELD_W = utg_pkg::UTG_FIELD_W,
  localparam int unsigned AW = FIELD_W + 1,
  localparam int unsigned SW = FIELD_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic [AW-1:0] num_i,
  input  logic [AW-1:0] den_i,
  output logic          fire_o,
  output logic          tick_o,
  output logic [AW-1:0] acc_o
);
  import utg_pkg::*;

  logic [AW-1:0] acc_q;
  logic          tick_q;
  logic [SW-1:0] sum;
  step_kind_e    kind;

  function automatic step_kind_e classify(input logic [SW-1:0] s,
                                          input logic [AW-1:0] n,
                                          input logic [AW-1:0] d);
    if (n >= d)             return STEP_SATURATE;
    if (s >= {1'b0, d})     return STEP_FIRE;
    return STEP_ACCUM;
  endfunction

  function automatic logic [AW-1:0] settle(input step_kind_e k,
                                           input logic [SW-1:0] s,
                                           input logic [AW-1:0] d);
    logic [SW-1:0] diff;
    diff = s - {1'b0, d};
    case (k)
      STEP_ACCUM: return s[AW-1:0];
      STEP_FIRE:  return diff[AW-1:0];
      default:    return '0;
    endcase
  endfunction

  assign sum    = {1'b0, acc_q} + {1'b0, num_i};
  assign kind   = classify(sum, num_i, den_i);
  assign fire_o = (kind != STEP_ACCUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= settle(kind, sum, den_i);
      tick_q <= fire_o;
    end
  end

  assign tick_o = tick_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/utg_usec_counter.sv
module utg_usec_counter #(
  parameter int unsigned CNT_W = utg_pkg::UTG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (inc_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
  parameter int unsigned FIELD_W = utg_pkg::UTG_FIELD_W,
  parameter int unsigned CNT_W   = utg_pkg::UTG_CNT_W,
  localparam int unsigned CFG_W  = 2 * FIELD_W,
  localparam int unsigned AW     = FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  output logic             usec_tick,
  output logic [CNT_W-1:0] usec_count
);
  logic [AW-1:0] num_val;
  logic [AW-1:0] den_val;
  logic [AW-1:0] acc_level;
  logic          step_fire;
  logic          count_inc;

  utg_cfg_reg #(.FIELD_W(FIELD_W)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_o   (cfg_rd_data),
    .num_o   (num_val),
    .den_o   (den_val)
  );

  utg_frac_accum #(.FIELD_W(FIELD_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cfg_wr_en),
    .num_i   (num_val),
    .den_i   (den_val),
    .fire_o  (step_fire),
    .tick_o  (usec_tick),
    .acc_o   (acc_level)
  );

  // a write cycle discards its pending tick
  assign count_inc = step_fire & ~cfg_wr_en;

  utg_usec_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (count_inc),
    .count_o (usec_count)
  );
endmodule

// File: rtl/usec_tick_gen_chk.sv
module usec_tick_gen_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned CFG_W  = 2 * FIELD_W,
  localparam int unsigned AW     = FIELD_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [CFG_W-1:0] cfg_wr_data,
  input logic [CFG_W-1:0] cfg_rd_data,
  input logic             usec_tick,
  input logic [CNT_W-1:0] usec_count,
  input logic [AW-1:0]    acc_level,
  input logic [AW-1:0]    num_val,
  input logic [AW-1:0]    den_val
);
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_level < den_val); // R4
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data)); // R2
  AST_SAT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (num_val >= den_val) && !cfg_wr_en |=> usec_tick); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    usec_tick |-> usec_count == $past(usec_count) + CNT_W'(1)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !usec_tick |-> $stable(usec_count)); // R6
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> !usec_tick); // R7
endmodule

bind usec_tick_gen usec_tick_gen_chk #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .usec_tick   (usec_tick),
  .usec_count  (usec_count),
  .acc_level   (acc_level),
  .num_val     (num_val),
  .den_val     (den_val)
);

// File: tb/usec_tick_gen_tb_top.sv
`timescale 1ns/1ps
module usec_tick_gen_tb_top;
  localparam int FW    = 8;
  localparam int CW    = 12;
  localparam int WIN   = 960;
  localparam int NVEC  = 10;
  localparam logic [15:0] VEC_CFG [NVEC] = '{
    16'h000B, 16'h000C, 16'h0019, 16'h045F, 16'h0453,
    16'h04BF, 16'h002F, 16'h0000, 16'h0300, 16'h0203};
  localparam int VEC_TICKS [NVEC] = '{80, 73, 36, 50, 57, 25, 20, 960, 960, 720};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          tick;
  logic [CW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usec_tick_gen #(.FIELD_W(FW), .CNT_W(CW)) dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_wr_en (wr_en), .cfg_wr_data (wr_data),
    .cfg_rd_data (rd_data), .usec_tick (tick), .usec_count (cnt));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int gap_lo(input int n, input int d);
    if (n >= d) return 1;
    return d / n;
  endfunction

  function automatic int gap_hi(input int n, input int d);
    if (n >= d) return 1;
    return (d + n - 1) / n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n_first;
    logic [CW-1:0] c0;
    bit wrapped;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", int'(tick), 0);
    check("R1 count in reset", int'(cnt), 0);
    check("R1 cfg in reset", int'(rd_data), 16'h000B);

    rst_n = 1'b1;
    n_first = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (tick) begin n_first = i; break; end
    end
    check("R8 first tick after reset", n_first, 12);

    // ratio table
    for (int v = 0; v < NVEC; v++) begin
      int num, den, ticks, last, gmin, gmax;
      logic [CW-1:0] cs;
      num = int'(VEC_CFG[v][15:8]) + 1;
      den = int'(VEC_CFG[v][7:0]) + 1;
      write_cfg(VEC_CFG[v]);
      cs = cnt; ticks = 0; last = 0; gmin = 1 << 20; gmax = 0;
      for (int i = 1; i <= WIN; i++) begin
        @(negedge clk);
        if (tick) begin
          ticks++;
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
          last = i;
        end
      end
      check((num >= den) ? "R5 tick total" : "R3 tick total", ticks, VEC_TICKS[v]);
      check("R4 max gap", gmax, gap_hi(num, den));
      check("R4 min gap", gmin, gap_lo(num, den));
      check("R6 count delta", int'(cnt - cs), VEC_TICKS[v] % (1 << CW));
    end

    // R2 readback
    write_cfg(16'h045F);
    check("R2 readback", int'(rd_data), 16'h045F);

    // R7 write clears accumulator and keeps count
    write_cfg(16'h000B);
    repeat (5) @(negedge clk);
    c0 = cnt;
    write_cfg(16'h000B);
    check("R7 count kept over write", int'(cnt), int'(c0));
    check("R7 no tick on write edge", int'(tick), 0);
    n_first = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (tick) begin n_first = i; break; end
    end
    check("R7 restart spacing", n_first, 12);

    // R6 wrap with the 1/1 ratio
    write_cfg(16'h0000);
    c0 = cnt; wrapped = 1'b0;
    for (int i = 1; i <= (1 << CW); i++) begin
      logic [CW-1:0] prev;
      prev = cnt;
      @(negedge clk);
      if (prev == '1 && cnt == '0) wrapped = 1'b1;
    end
    check("R6 wrap seen", int'(wrapped), 1);
    check("R6 count after full wrap", int'(cnt), int'(c0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule